// File: doc/BRIEF.md
# NAND Cache-Program Burst Sequencer

This block is the host-side engine that writes a run of consecutive pages into a NAND device with cache programming. A user pulses a start request together with a starting row, a page count and a page length in bytes. The block then issues, page by page, the load command, the address cycles and the data bytes taken from a byte stream. Every page but the final one is confirmed with the cache-program command, so the device can take in the next page while it is still programming the previous one. The final page is confirmed with the ordinary program command.

Between pages the block waits until the device can accept more data. It watches either the ready/busy pin or the ready bits of a polled status byte, chosen per burst. Because the device only reports a page's outcome one step later, the block reads the previous-page status bit after each cache confirm. After the final confirm it reads both the previous-page bit and the current-page bit at once. Each outcome leaves on a result stream as a page index and a pass flag. The burst closes with a done pulse and a sticky fail summary. A wait that lasts too long aborts the burst with a timeout flag.

The bus side is one transfer per cycle: `nd_we_o` marks a write cycle, and `nd_cle_o` or `nd_ale_o` mark it as a command or an address. `nd_re_o` marks the cycle in which the status byte on `nd_dq_i` is taken.

Top module: `nand_cprog_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `fail_o`, `tmo_o`, `res_valid_o`, `din_ready_o`, `nd_we_o` and `nd_re_o` are all low.
- R2: Each page is written as the command byte 80h, then 5 address cycles, then `plen_i` data bytes, then a confirm command. The address cycles are column low = 00h, column high = 00h, then row bits 7:0, 15:8 and 23:16.
- R3: Pages 0 to N-2 are confirmed with 15h and page N-1 with 10h. A burst of N = 1 issues no 15h at all.
- R4: Page k of a burst uses row `row_i + k`, with carries across the row bytes.
- R5: After each confirm, no new 80h is written until the device is ready. With `poll_i` = 0 the block waits for `nd_rb_i` high and then issues one 70h and one status read. With `poll_i` = 1 it repeats 70h plus a status read until the ready bit is set: bit 6 after 15h, bit 5 after 10h.
- R6: After the cache confirm of page k (k ≥ 1), the status byte's bit 1 gives the result of page k-1. A status bit of 0 means pass, and the result is emitted with `res_pass_o` = 1.
- R7: After the final 10h and true ready, bit 1 gives page N-2 and, on the next cycle, bit 0 gives page N-1. When N = 1, only page 0 is reported, from bit 0.
- R8: Exactly N results appear per completed burst, in ascending page order starting at 0.
- R9: `done_o` pulses for one cycle after the last result. `fail_o` then equals the OR of all page failures and a timeout, and it holds until the next start.
- R10: If a ready wait lasts `TMO_CYC` cycles, the burst aborts. `tmo_o` and `fail_o` go high, `done_o` pulses, and no further bus write follows.
- R11: A data byte is consumed and written only in a cycle with `din_valid_i` and `din_ready_o` both high. Gaps in the stream pause the data phase without losing or repeating bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a burst (taken when idle) |
| row_i | input | ROW_W | First row address |
| npages_i | input | CNT_W | Number of pages N |
| plen_i | input | LEN_W | Data bytes per page |
| poll_i | input | 1 | 1: poll status bits for ready; 0: use the ready/busy pin |
| din_valid_i | input | 1 | Data byte valid |
| din_i | input | 8 | Data byte |
| din_ready_o | output | 1 | Block accepts a data byte |
| nd_cle_o | output | 1 | Bus cycle is a command |
| nd_ale_o | output | 1 | Bus cycle is an address |
| nd_we_o | output | 1 | Bus write cycle |
| nd_re_o | output | 1 | Bus status read cycle |
| nd_dq_o | output | 8 | Bus write byte |
| nd_dq_i | input | 8 | Bus read byte (status) |
| nd_rb_i | input | 1 | Device ready (high) / busy (low) |
| res_valid_o | output | 1 | Page result valid |
| res_page_o | output | CNT_W | Page index of the result |
| res_pass_o | output | 1 | Page passed |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst pulse |
| fail_o | output | 1 | Any page failed or timeout |
| tmo_o | output | 1 | Burst aborted by timeout |

## Verification
The bursts cover one, two and several pages, in both pin-wait and status-poll modes. Each uses a different per-page failure pattern, so a result read from the wrong status bit or credited to the wrong page shows up as a mismatch. Starting rows sit next to byte boundaries (00FEh, ABCDFFh, 00FFFEh), which separates a correct multi-byte increment from one that drops the carry. Stalled data streams separate proper handshaking from free-running byte counts. A device that never turns ready exercises the abort path in each mode.

// File: rtl/nand_cprog_pkg.sv
package nand_cprog_pkg;

  localparam logic [7:0] CMD_LOAD  = 8'h80;
  localparam logic [7:0] CMD_CACHE = 8'h15;
  localparam logic [7:0] CMD_PROG  = 8'h10;
  localparam logic [7:0] CMD_STAT  = 8'h70;

  localparam int SB_CUR       = 0;
  localparam int SB_PREV      = 1;
  localparam int SB_TRUE_RDY  = 5;
  localparam int SB_CACHE_RDY = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_ADDR, S_DATA, S_CONF, S_SETTLE,
    S_WAITRB, S_SCMD, S_SRD, S_SEVAL, S_EMIT2, S_DONE
  } seq_st_t;

endpackage

// File: rtl/nand_cyc_timer.sv
module nand_cyc_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic exp_o
);
  localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign exp_o = (cnt_q == W'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)              cnt_d = '0;
    else if (run_i && !exp_o) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10
  exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_o && !clr_i) |=> exp_o);

endmodule

// File: rtl/nand_addr_gen.sv
module nand_addr_gen #(
  parameter int ROW_W = 24,
  parameter int COL_W = 16,
  localparam int COL_BYTES = (COL_W + 7) / 8,
  localparam int ROW_BYTES = (ROW_W + 7) / 8,
  localparam int ADDR_CYC  = COL_BYTES + ROW_BYTES,
  localparam int AIW       = $clog2(ADDR_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             inc_i,
  input  logic [AIW-1:0]   idx_i,
  output logic [7:0]       byte_o
);
  logic [ROW_W-1:0]       row_q, row_d;
  logic [ROW_BYTES*8-1:0] row_pad;
  logic [7:0]             abyte [ADDR_CYC];

  assign row_pad = (ROW_BYTES*8)'(row_q);

  for (genvar i = 0; i < ADDR_CYC; i++) begin : g_abyte
    if (i < COL_BYTES) begin : g_col
      assign abyte[i] = 8'h00;
    end else begin : g_row
      assign abyte[i] = row_pad[(i-COL_BYTES)*8 +: 8];
    end
  end

  assign byte_o = (32'(idx_i) < ADDR_CYC) ? abyte[idx_i] : 8'h00;

  always_comb begin
    row_d = row_q;
    if (load_i)     row_d = row_i;
    else if (inc_i) row_d = row_q + ROW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

endmodule

// File: rtl/nand_cprog_seq.sv
module nand_cprog_seq
  import nand_cprog_pkg::*;
#(
  parameter int ROW_W   = 24,
  parameter int COL_W   = 16,
  parameter int CNT_W   = 8,
  parameter int LEN_W   = 16,
  parameter int WB_CYC  = 2,
  parameter int TMO_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [CNT_W-1:0] npages_i,
  input  logic [LEN_W-1:0] plen_i,
  input  logic             poll_i,
  input  logic             din_valid_i,
  input  logic [7:0]       din_i,
  output logic             din_ready_o,
  output logic             nd_cle_o,
  output logic             nd_ale_o,
  output logic             nd_we_o,
  output logic             nd_re_o,
  output logic [7:0]       nd_dq_o,
  input  logic [7:0]       nd_dq_i,
  input  logic             nd_rb_i,
  output logic             res_valid_o,
  output logic [CNT_W-1:0] res_page_o,
  output logic             res_pass_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             tmo_o
);
  localparam int ADDR_CYC = (COL_W + 7) / 8 + (ROW_W + 7) / 8;
  localparam int AIW      = $clog2(ADDR_CYC);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] npg_q, npg_d, pg_q, pg_d;
  logic [LEN_W-1:0] plen_q, plen_d, bcnt_q, bcnt_d;
  logic [AIW-1:0]   acnt_q, acnt_d;
  logic [3:0]       stat_q, stat_d;   // {cache_rdy, true_rdy, prev, cur}
  logic             poll_q, poll_d, fail_q, fail_d, tmo_q, tmo_d;

  logic       row_load, row_inc, settle_exp, wait_exp, in_wait;
  logic [7:0] addr_byte;
  logic       last, rdy_bit;
  logic       stat_unused;

  assign stat_unused = ^{nd_dq_i[7], nd_dq_i[4:2]};

  nand_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk(clk), .rst_n(rst_int_n), .load_i(row_load), .row_i(row_i),
    .inc_i(row_inc), .idx_i(acnt_q), .byte_o(addr_byte)
  );

  nand_cyc_timer #(.LIMIT(WB_CYC)) u_settle (
    .clk(clk), .rst_n(rst_int_n), .clr_i(st_q != S_SETTLE),
    .run_i(st_q == S_SETTLE), .exp_o(settle_exp)
  );

  assign in_wait = (st_q == S_WAITRB) || (st_q == S_SCMD) ||
                   (st_q == S_SRD)    || (st_q == S_SEVAL);

  nand_cyc_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_int_n), .clr_i(st_q == S_CONF),
    .run_i(in_wait), .exp_o(wait_exp)
  );

  assign last    = (pg_q == npg_q - CNT_W'(1));
  assign rdy_bit = last ? stat_q[2] : stat_q[3];

  // result stream
  always_comb begin
    res_valid_o = 1'b0;
    res_page_o  = pg_q;
    res_pass_o  = 1'b0;
    if (st_q == S_EMIT2) begin
      res_valid_o = 1'b1;
      res_pass_o  = !stat_q[0];
    end else if (st_q == S_SEVAL && rdy_bit) begin
      if (last && npg_q == CNT_W'(1)) begin
        res_valid_o = 1'b1;
        res_pass_o  = !stat_q[0];
      end else if (last || pg_q != '0) begin
        res_valid_o = 1'b1;
        res_page_o  = pg_q - CNT_W'(1);
        res_pass_o  = !stat_q[1];
      end
    end
  end

  // next state
  always_comb begin
    st_d = st_q; npg_d = npg_q; pg_d = pg_q; plen_d = plen_q;
    bcnt_d = bcnt_q; acnt_d = acnt_q; stat_d = stat_q;
    poll_d = poll_q; fail_d = fail_q; tmo_d = tmo_q;
    row_load = 1'b0; row_inc = 1'b0;
    case (st_q)
      S_IDLE: if (start_i) begin
        npg_d = npages_i; plen_d = plen_i; poll_d = poll_i;
        pg_d = '0; fail_d = 1'b0; tmo_d = 1'b0; row_load = 1'b1;
        st_d = (npages_i == '0) ? S_DONE : S_LOAD;
      end
      S_LOAD: begin
        acnt_d = '0;
        st_d   = S_ADDR;
      end
      S_ADDR: begin
        acnt_d = acnt_q + AIW'(1);
        if (acnt_q == AIW'(ADDR_CYC - 1)) begin
          bcnt_d = '0;
          st_d   = (plen_q == '0) ? S_CONF : S_DATA;
        end
      end
      S_DATA: if (din_valid_i) begin
        bcnt_d = bcnt_q + LEN_W'(1);
        if (bcnt_q == plen_q - LEN_W'(1)) st_d = S_CONF;
      end
      S_CONF:   st_d = S_SETTLE;
      S_SETTLE: if (settle_exp) st_d = poll_q ? S_SCMD : S_WAITRB;
      S_WAITRB: begin
        if (nd_rb_i) st_d = S_SCMD;
        else if (wait_exp) begin
          tmo_d = 1'b1; fail_d = 1'b1; st_d = S_DONE;
        end
      end
      S_SCMD: st_d = S_SRD;
      S_SRD: begin
        stat_d = {nd_dq_i[SB_CACHE_RDY], nd_dq_i[SB_TRUE_RDY],
                  nd_dq_i[SB_PREV], nd_dq_i[SB_CUR]};
        st_d   = S_SEVAL;
      end
      S_SEVAL: begin
        if (!rdy_bit) begin
          if (wait_exp) begin
            tmo_d = 1'b1; fail_d = 1'b1; st_d = S_DONE;
          end else begin
            st_d = S_SCMD;
          end
        end else if (!last) begin
          pg_d = pg_q + CNT_W'(1); row_inc = 1'b1; st_d = S_LOAD;
        end else begin
          st_d = (npg_q > CNT_W'(1)) ? S_EMIT2 : S_DONE;
        end
      end
      S_EMIT2: st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (res_valid_o && !res_pass_o) fail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q <= S_IDLE; npg_q <= '0; pg_q <= '0; plen_q <= '0;
      bcnt_q <= '0; acnt_q <= '0; stat_q <= '0;
      poll_q <= 1'b0; fail_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      st_q <= st_d; npg_q <= npg_d; pg_q <= pg_d; plen_q <= plen_d;
      bcnt_q <= bcnt_d; acnt_q <= acnt_d; stat_q <= stat_d;
      poll_q <= poll_d; fail_q <= fail_d; tmo_q <= tmo_d;
    end
  end

  // bus drive
  always_comb begin
    nd_cle_o = 1'b0; nd_ale_o = 1'b0; nd_we_o = 1'b0; nd_re_o = 1'b0;
    nd_dq_o  = 8'h00;
    case (st_q)
      S_LOAD: begin nd_we_o = 1'b1; nd_cle_o = 1'b1; nd_dq_o = CMD_LOAD; end
      S_ADDR: begin nd_we_o = 1'b1; nd_ale_o = 1'b1; nd_dq_o = addr_byte; end
      S_DATA: begin nd_we_o = din_valid_i; nd_dq_o = din_i; end
      S_CONF: begin
        nd_we_o = 1'b1; nd_cle_o = 1'b1;
        nd_dq_o = last ? CMD_PROG : CMD_CACHE;
      end
      S_SCMD: begin nd_we_o = 1'b1; nd_cle_o = 1'b1; nd_dq_o = CMD_STAT; end
      S_SRD:  nd_re_o = 1'b1;
      default: ;
    endcase
  end

  assign din_ready_o = (st_q == S_DATA);
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_DONE);
  assign fail_o      = fail_q;
  assign tmo_o       = tmo_q;

  // R8
  res_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_valid_o |-> (res_page_o < npg_q));

  // R8
  res_order_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (res_valid_o && $past(res_valid_o)) |-> (res_page_o == $past(res_page_o) + CNT_W'(1)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !busy_o);

  // R10
  tmo_done_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(tmo_o) |-> done_o);

  // R5
  poll_rdy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (nd_re_o && !poll_q) |-> $past(nd_rb_i, 2));

endmodule

// File: tb/sim_nand_cprog_seq.sv
`timescale 1ns/1ps
module sim_nand_cprog_seq;
  localparam int TMO = 100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, poll, din_valid, din_ready;
  logic [23:0] row;
  logic [7:0]  npages, din, nd_dq_o, nd_dq_i, res_page;
  logic [15:0] plen;
  logic        cle, ale, we, re, rb, res_valid, res_pass, busy, done, fail, tmo;

  nand_cprog_seq #(.TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .row_i(row), .npages_i(npages),
    .plen_i(plen), .poll_i(poll), .din_valid_i(din_valid), .din_i(din),
    .din_ready_o(din_ready), .nd_cle_o(cle), .nd_ale_o(ale), .nd_we_o(we),
    .nd_re_o(re), .nd_dq_o(nd_dq_o), .nd_dq_i(nd_dq_i), .nd_rb_i(rb),
    .res_valid_o(res_valid), .res_page_o(res_page), .res_pass_o(res_pass),
    .busy_o(busy), .done_o(done), .fail_o(fail), .tmo_o(tmo)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device model
  bit          m_clr = 1'b0, stuck = 1'b0, feeding = 1'b0, gaps = 1'b0, tog = 1'b0;
  logic [7:0]  cur_mask = 8'h00;
  int          cur_busy = 4, seed = 0;
  int          m_bcnt, m_pg, seq_err, lcnt, feed_cnt;
  bit          m_final, m_b1, m_b0, m_rdy;
  logic [9:0]  lg [0:1023];

  assign m_rdy   = (m_bcnt == 0) && !stuck;
  assign rb      = m_rdy;
  assign nd_dq_i = {1'b0, m_rdy, m_rdy & m_final, 3'b000, m_b1, m_b0};

  always @(posedge clk) begin
    if (m_clr) begin
      m_bcnt <= 0; m_final <= 0; m_b1 <= 0; m_b0 <= 0; m_pg <= 0;
      seq_err <= 0; lcnt <= 0; feed_cnt <= 0;
    end else begin
      if (we) begin
        if (lcnt < 1024) lg[lcnt] <= {cle, ale, nd_dq_o};
        lcnt <= lcnt + 1;
      end
      if (din_valid && din_ready) feed_cnt <= feed_cnt + 1;
      if (we && cle && nd_dq_o == 8'h15) begin
        m_bcnt <= cur_busy; m_final <= 0; m_b0 <= 0;
        m_b1 <= (m_pg > 0) ? cur_mask[m_pg-1] : 1'b0; m_pg <= m_pg + 1;
      end else if (we && cle && nd_dq_o == 8'h10) begin
        m_bcnt <= 2 * cur_busy; m_final <= 1;
        m_b1 <= (m_pg > 0) ? cur_mask[m_pg-1] : 1'b0; m_b0 <= cur_mask[m_pg];
        m_pg <= m_pg + 1;
      end else begin
        if (we && cle && nd_dq_o == 8'h80 && !m_rdy) seq_err <= seq_err + 1;
        if (m_bcnt > 0) m_bcnt <= m_bcnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    din_valid = feeding && (gaps ? tog : 1'b1);
    tog = ~tog;
    din = 8'(seed + feed_cnt);
  end

  // result collector
  int rcnt;
  bit done_seen;
  logic [7:0] rpage [0:15];
  bit         rpass [0:15];
  always @(negedge clk) begin
    if (m_clr) begin
      rcnt = 0; done_seen = 0;
    end else begin
      if (res_valid) begin
        if (rcnt < 16) begin rpage[rcnt] = res_page; rpass[rcnt] = res_pass; end
        rcnt++;
      end
      if (done) done_seen = 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // vector fields: [63:56] n [55:48] plen [47:24] row [23:16] fail mask
  //                [15:8] busy cycles [1] stream gaps [0] poll mode
  localparam logic [63:0] VEC [0:5] = '{
    {8'd3, 8'd4,  24'h000010, 8'b00000000, 8'd6,  8'b00},
    {8'd4, 8'd3,  24'h0000FE, 8'b00000101, 8'd9,  8'b11},
    {8'd1, 8'd5,  24'h123456, 8'b00000001, 8'd5,  8'b00},
    {8'd2, 8'd2,  24'hABCDFF, 8'b00000010, 8'd4,  8'b01},
    {8'd5, 8'd6,  24'h00FFFE, 8'b00010000, 8'd12, 8'b10},
    {8'd6, 8'd2,  24'h000007, 8'b00100001, 8'd0,  8'b01}
  };

  task automatic clear_model();
    @(posedge clk); m_clr <= 1'b1;
    @(posedge clk);
    @(posedge clk); m_clr <= 1'b0;
    @(negedge clk);
  endtask

  task automatic launch(input int n, input int pl, input logic [23:0] r, input bit pm);
    @(negedge clk);
    start = 1'b1; npages = 8'(n); plen = 16'(pl); row = r; poll = pm; feeding = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 5000 && !done_seen; w++) @(negedge clk);
    chk(done_seen, "R9 done pulse seen", int'(done_seen), 1);
  endtask

  task automatic run_vec(input int vi);
    int n, pl, bsy, ne, e, mism, n70, n15, r6b, r7b, ordb;
    logic [23:0] r0, rk;
    logic [7:0]  mask;
    bit pm, expfail;
    logic [9:0] ex [0:1023];
    n = int'(VEC[vi][63:56]); pl = int'(VEC[vi][55:48]); r0 = VEC[vi][47:24];
    mask = VEC[vi][23:16]; bsy = int'(VEC[vi][15:8]);
    gaps = VEC[vi][1]; pm = VEC[vi][0];
    cur_mask = mask; cur_busy = bsy; seed = vi * 37; stuck = 1'b0;
    clear_model();
    launch(n, pl, r0, pm);
    // expected bus log without status commands
    ne = 0;
    for (int k = 0; k < n; k++) begin
      rk = r0 + 24'(k);
      ex[ne++] = {2'b10, 8'h80};
      ex[ne++] = {2'b01, 8'h00};
      ex[ne++] = {2'b01, 8'h00};
      ex[ne++] = {2'b01, rk[7:0]};
      ex[ne++] = {2'b01, rk[15:8]};
      ex[ne++] = {2'b01, rk[23:16]};
      for (int j = 0; j < pl; j++) ex[ne++] = {2'b00, 8'(seed + k * pl + j)};
      ex[ne++] = {2'b10, (k == n - 1) ? 8'h10 : 8'h15};
    end
    e = 0; mism = 0; n70 = 0; n15 = 0;
    for (int i = 0; i < lcnt && i < 1024; i++) begin
      if (lg[i] == {2'b10, 8'h70}) n70++;
      else begin
        if (lg[i] == {2'b10, 8'h15}) n15++;
        if (e >= ne || lg[i] != ex[e]) mism++;
        e++;
      end
    end
    if (e != ne) mism++;
    chk(mism == 0, $sformatf("R2 R4 R11 bus sequence vec%0d", vi), mism, 0);
    chk(n15 == n - 1, $sformatf("R3 cache confirms vec%0d", vi), n15, n - 1);
    chk(seq_err == 0, $sformatf("R5 load while busy vec%0d", vi), seq_err, 0);
    if (pm) chk(n70 >= n, $sformatf("R5 poll reads vec%0d", vi), n70, n);
    else    chk(n70 == n, $sformatf("R5 pin-mode reads vec%0d", vi), n70, n);
    chk(rcnt == n, $sformatf("R8 result count vec%0d", vi), rcnt, n);
    r6b = 0; r7b = 0; ordb = 0;
    for (int i = 0; i < rcnt && i < 16; i++) begin
      if (int'(rpage[i]) != i) ordb++;
      if (rpass[i] != !mask[i]) begin
        if (i < n - 2) r6b++; else r7b++;
      end
    end
    chk(ordb == 0, $sformatf("R8 result order vec%0d", vi), ordb, 0);
    chk(r6b == 0, $sformatf("R6 previous-page results vec%0d", vi), r6b, 0);
    chk(r7b == 0, $sformatf("R7 final results vec%0d", vi), r7b, 0);
    expfail = |(mask & 8'((1 << n) - 1));
    repeat (3) @(negedge clk);
    chk(fail == expfail, $sformatf("R9 fail summary held vec%0d", vi), int'(fail), int'(expfail));
    chk(!tmo && !busy, $sformatf("R9 idle no timeout vec%0d", vi), int'(tmo || busy), 0);
    feeding = 1'b0;
  endtask

  task automatic run_stuck(input int n, input bit pm, input string nm);
    int l0;
    cur_mask = 8'h00; cur_busy = 3; seed = 5; gaps = 1'b0; stuck = 1'b1;
    clear_model();
    launch(n, 2, 24'h000100, pm);
    chk(tmo == 1'b1, {"R10 timeout flag ", nm}, int'(tmo), 1);
    chk(fail == 1'b1, {"R10 fail on timeout ", nm}, int'(fail), 1);
    chk(rcnt == 0, {"R10 no results ", nm}, rcnt, 0);
    l0 = lcnt;
    repeat (20) @(negedge clk);
    chk(lcnt == l0, {"R10 bus silent after abort ", nm}, lcnt - l0, 0);
    feeding = 1'b0; stuck = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; npages = 8'd0; plen = 16'd0; row = 24'd0; poll = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !fail && !tmo, "R1 reset status", int'({busy, done, fail, tmo}), 0);
    chk(!we && !re && !din_ready && !res_valid, "R1 reset bus idle",
        int'({we, re, din_ready, res_valid}), 0);
    for (int v = 0; v < 6; v++) run_vec(v);
    run_stuck(3, 1'b0, "pin mode");
    run_stuck(1, 1'b1, "poll mode");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule